// File: doc/BRIEF.md
# Transmit Buffer Abort Controller

This block keeps the scheduling and abort bookkeeping for three transmit message buffers of a CAN-style controller. A CPU reaches two byte-wide registers through a simple write strobe, a one-bit address and a combinational read port. The flag register reports, for each buffer, whether it is empty and whether its last abort was acknowledged. The control register holds the per-buffer abort requests and the transmitter-empty interrupt enables. The transmit engine tells the block which buffer is on the bus and when a transmission completes.

Each buffer runs its own small state machine with three named states. `SLOT_IDLE` means the buffer is empty and not scheduled. `SLOT_QUEUED` means it is loaded and scheduled. `SLOT_ABORT` means it is scheduled and an abort has been requested. The transitions are:
- *schedule*: `SLOT_IDLE` to `SLOT_QUEUED`, when the CPU writes 1 to the buffer's empty bit.
- *request*: `SLOT_QUEUED` to `SLOT_ABORT`, when the CPU writes 1 to the buffer's abort bit.
- *complete*: `SLOT_QUEUED` or `SLOT_ABORT` to `SLOT_IDLE`, when the engine reports that the transmission finished.
- *grant*: `SLOT_ABORT` to `SLOT_IDLE`, when the buffer is not on the bus. This transition also sets the acknowledge flag.
- *soft reset*: from any state to `SLOT_IDLE`.

The interrupt line is the registered OR of the per-buffer "empty and enabled" conditions.

Top module: `txbuf_abort_ctrl`

## Requirements
- R1: After reset the flag register (address 0) reads 0x07: empty bits 2:0 are 1 and acknowledge bits 6:4 are 0. The control register (address 1) reads 0x00. Bits 7 and 3 of both registers always read 0.
- R2: A write to address 0 acts per bit. A 1 in bit i (i = 0..2) clears empty flag i and schedules buffer i. A 1 in bit 4+i clears acknowledge flag i. A 0 in any bit changes nothing.
- R3: A write to address 1 loads the interrupt enables from bits 2:0. Data bits 7 and 3 are ignored.
- R4: A 1 in bit 4+i of a control write sets abort request i only if buffer i is scheduled (empty flag 0) at that moment. Writing 0 never clears an abort request.
- R5: A pending abort for a buffer that is not on the bus is granted at the next clock edge. The grant sets the buffer's empty flag and acknowledge flag and clears its abort request in that same edge.
- R6: While the buffer is on the bus (tx_active high with tx_sel = i), its abort request stays pending and its empty flag stays 0.
- R7: A completion (tx_done with tx_active and tx_sel = i) sets empty flag i and clears abort request i. The acknowledge flag is not set, even if an abort was pending.
- R8: irq is high one cycle after any buffer has both its empty flag and its interrupt enable at 1.
- R9: While soft_rst is high, both registers are forced to their reset values (0x07 and 0x00) and CPU writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset; holds both registers at their reset values |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 1 | Register select: 0 = flag register, 1 = control register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Combinational read data of the selected register |
| tx_active | input | 1 | Transmit engine is sending the buffer named by tx_sel |
| tx_sel | input | 2 | Index of the buffer on the bus |
| tx_done | input | 1 | One-cycle pulse: the transmission of buffer tx_sel has completed |
| irq | output | 1 | Registered transmitter-empty interrupt |

## Verification
Register writes and completions show up on cpu_rdata after the clock edge that takes them. An abort request shows one cycle later, and its grant lands on the following edge if the buffer is off the bus. The interrupt trails the flag change by one more edge. The bench drives every input at a falling edge and reads back at the next falling edge, so each check falls exactly in the cycle the result is due. For the interrupt, it first confirms the line is still low at the edge where the flag changes, and then confirms it is high one cycle later. The sweep repeats every scenario for each of the three buffers and builds the expected bytes from shifted bit positions.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_QUEUED = 2'd1,
        SLOT_ABORT  = 2'd2
    } slot_state_e;

endpackage

// File: rtl/txbuf_slot.sv
module txbuf_slot
    import txbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic sched_wr,
    input  logic ack_clr_wr,
    input  logic abort_wr,
    input  logic on_bus,
    input  logic done,
    output logic empty,
    output logic abort_pend,
    output logic ack
);

    slot_state_e state_q, state_nxt;
    logic        ack_q, ack_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            ack_q   <= ack_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        ack_nxt   = ack_q & ~ack_clr_wr;
        if (soft_rst) begin
            state_nxt = SLOT_IDLE;
            ack_nxt   = 1'b0;
        end else begin
            unique case (state_q)
                SLOT_IDLE: begin
                    if (sched_wr) state_nxt = SLOT_QUEUED;
                end
                SLOT_QUEUED: begin
                    if (done)          state_nxt = SLOT_IDLE;
                    else if (abort_wr) state_nxt = SLOT_ABORT;
                end
                SLOT_ABORT: begin
                    if (done) begin
                        state_nxt = SLOT_IDLE;
                    end else if (!on_bus) begin
                        state_nxt = SLOT_IDLE;
                        ack_nxt   = 1'b1;
                    end
                end
                default: state_nxt = SLOT_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        empty      = 1'b0;
        abort_pend = 1'b0;
        unique case (state_q)
            SLOT_IDLE:   empty = 1'b1;
            SLOT_QUEUED: empty = 1'b0;
            SLOT_ABORT:  abort_pend = 1'b1;
            default:     empty = 1'b1;
        endcase
    end

    assign ack = ack_q;

endmodule

// File: rtl/txbuf_irq.sv
module txbuf_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] empty,
    input  logic [N-1:0] ie,
    output logic         irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(empty & ie);
    end

endmodule

// File: rtl/txbuf_abort_ctrl.sv
module txbuf_abort_ctrl #(
    parameter int NBUF   = 3,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cpu_wr,
    input  logic              cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              tx_active,
    input  logic [SEL_W-1:0]  tx_sel,
    input  logic              tx_done,
    output logic              irq
);

    localparam int HI_LSB = DATA_W / 2;

    logic            wr_flag, wr_ctrl;
    logic [NBUF-1:0] empty_vec, ack_vec, abort_vec, ie_q, on_bus;
    logic [DATA_W-1:0] flag_byte, ctrl_byte;
    logic            unused_wbits;

    assign wr_flag = cpu_wr && !cpu_addr;
    assign wr_ctrl = cpu_wr &&  cpu_addr;
    assign unused_wbits = ^{cpu_wdata[DATA_W-1:HI_LSB+NBUF], cpu_wdata[HI_LSB-1:NBUF]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ie_q <= '0;
        else if (soft_rst) ie_q <= '0;
        else if (wr_ctrl)  ie_q <= cpu_wdata[NBUF-1:0];
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        assign on_bus[g] = tx_active && (tx_sel == SEL_W'(g));
        txbuf_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst   (soft_rst),
            .sched_wr   (wr_flag & cpu_wdata[g]),
            .ack_clr_wr (wr_flag & cpu_wdata[HI_LSB+g]),
            .abort_wr   (wr_ctrl & cpu_wdata[HI_LSB+g]),
            .on_bus     (on_bus[g]),
            .done       (tx_done & on_bus[g]),
            .empty      (empty_vec[g]),
            .abort_pend (abort_vec[g]),
            .ack        (ack_vec[g])
        );
    end

    always_comb begin
        flag_byte = '0;
        ctrl_byte = '0;
        flag_byte[NBUF-1:0]      = empty_vec;
        flag_byte[HI_LSB +: NBUF] = ack_vec;
        ctrl_byte[NBUF-1:0]      = ie_q;
        ctrl_byte[HI_LSB +: NBUF] = abort_vec;
    end

    assign cpu_rdata = cpu_addr ? ctrl_byte : flag_byte;

    txbuf_irq #(.N(NBUF)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .empty (empty_vec),
        .ie    (ie_q),
        .irq   (irq)
    );

endmodule

// File: rtl/txbuf_abort_ctrl_chk.sv
module txbuf_abort_ctrl_chk #(
    parameter int NBUF  = 3,
    parameter int SEL_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            soft_rst,
    input logic            tx_active,
    input logic [SEL_W-1:0] tx_sel,
    input logic            tx_done,
    input logic            irq,
    input logic [NBUF-1:0] empty_vec,
    input logic [NBUF-1:0] ack_vec,
    input logic [NBUF-1:0] abort_vec,
    input logic [NBUF-1:0] ie_q
);

    for (genvar g = 0; g < NBUF; g++) begin : g_chk
        p_grant_off_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ack_vec[g]) |-> $past(!(tx_active && tx_sel == SEL_W'(g))));

        p_abort_gone_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(empty_vec[g]) |-> !abort_vec[g]);

        p_abort_not_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(abort_vec[g]) |-> empty_vec[g]);

        p_done_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_done && tx_active && tx_sel == SEL_W'(g) && !empty_vec[g]) |=> empty_vec[g]);

        p_hold_on_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (abort_vec[g] && tx_active && tx_sel == SEL_W'(g) && !tx_done && !soft_rst)
            |=> (abort_vec[g] && !empty_vec[g]));
    end

    p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (&empty_vec && ack_vec == '0 && abort_vec == '0 && ie_q == '0));

    p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(empty_vec & ie_q))));

endmodule

bind txbuf_abort_ctrl txbuf_abort_ctrl_chk #(.NBUF(NBUF), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .tx_active (tx_active),
    .tx_sel    (tx_sel),
    .tx_done   (tx_done),
    .irq       (irq),
    .empty_vec (empty_vec),
    .ack_vec   (ack_vec),
    .abort_vec (abort_vec),
    .ie_q      (ie_q)
);

// File: tb/tb_txbuf_abort_ctrl.sv
module tb_txbuf_abort_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       tx_active = 1'b0;
    logic [1:0] tx_sel = 2'd0;
    logic       tx_done = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    txbuf_abort_ctrl dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .tx_active(tx_active), .tx_sel(tx_sel),
        .tx_done(tx_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        cpu_addr = a;
        #1;
        v = cpu_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_wdata = 8'h00;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, v); chk("R1 flag reset", v, 8'h07);
        rd(1, v); chk("R1 ctrl reset", v, 8'h00);
        chk("R1 irq reset", {7'd0, irq}, 8'h00);

        for (int i = 0; i < 3; i++) begin
            logic [7:0] eb, ab;
            eb = 8'(1 << i);
            ab = 8'(1 << (4 + i));

            // abort on an empty buffer is ignored
            wr(1, ab);
            rd(1, v); chk("R4 abort on empty ignored", v, 8'h00);

            // schedule
            wr(0, eb);
            rd(0, v); chk("R2 schedule clears empty", v, 8'h07 & ~eb);
            wr(0, 8'h00);
            rd(0, v); chk("R2 zero write no effect", v, 8'h07 & ~eb);

            // enable, reserved bits ignored
            wr(1, 8'h88 | eb);
            rd(1, v); chk("R3 enable load", v, eb);
            @(negedge clk);
            chk("R8 irq low while queued", {7'd0, irq}, 8'h00);

            // abort while on the bus: pending
            tx_active = 1'b1; tx_sel = 2'(i);
            wr(1, ab | eb);
            rd(1, v); chk("R4 abort set", v, ab | eb);
            @(negedge clk);
            rd(1, v); chk("R6 abort pending on bus", v, ab | eb);
            rd(0, v); chk("R6 empty stays 0 on bus", v, 8'h07 & ~eb);
            wr(1, eb);
            rd(1, v); chk("R4 zero write keeps abort", v, ab | eb);

            // release the bus: grant
            tx_active = 1'b0;
            @(negedge clk);
            rd(0, v); chk("R5 grant sets empty and ack", v, 8'h07 | ab);
            rd(1, v); chk("R5 grant clears abort", v, eb);
            chk("R8 irq not yet", {7'd0, irq}, 8'h00);
            @(negedge clk);
            chk("R8 irq one cycle later", {7'd0, irq}, 8'h01);

            wr(0, ab);
            rd(0, v); chk("R2 ack clear", v, 8'h07);
            wr(1, 8'h00);
            @(negedge clk);
            chk("R8 irq drops", {7'd0, irq}, 8'h00);

            // completion with abort pending: no ack
            wr(0, eb);
            tx_active = 1'b1; tx_sel = 2'(i);
            wr(1, ab);
            tx_done = 1'b1;
            @(negedge clk);
            tx_done = 1'b0; tx_active = 1'b0;
            rd(0, v); chk("R7 completion no ack", v, 8'h07);
            rd(1, v); chk("R7 completion clears abort", v, 8'h00);

            // plain completion
            wr(0, eb);
            tx_active = 1'b1; tx_sel = 2'(i); tx_done = 1'b1;
            @(negedge clk);
            tx_done = 1'b0; tx_active = 1'b0;
            rd(0, v); chk("R7 plain completion", v, 8'h07);

            // another buffer on the bus does not block the grant
            wr(0, eb);
            tx_active = 1'b1; tx_sel = 2'((i + 1) % 3);
            wr(1, ab);
            rd(1, v); chk("R4 abort set other busy", v, ab);
            @(negedge clk);
            tx_active = 1'b0;
            rd(0, v); chk("R5 grant while other on bus", v, 8'h07 | ab);
            wr(0, ab);
        end

        // soft reset
        wr(0, 8'h07);
        rd(0, v); chk("R2 schedule all", v, 8'h00);
        wr(1, 8'h07);
        rd(1, v); chk("R3 enable all", v, 8'h07);
        soft_rst = 1'b1;
        wr(1, 8'h77);
        rd(0, v); chk("R9 flag forced", v, 8'h07);
        rd(1, v); chk("R9 ctrl forced", v, 8'h00);
        wr(0, 8'h07);
        rd(0, v); chk("R9 flag write ignored", v, 8'h07);
        soft_rst = 1'b0;
        @(negedge clk);
        chk("R9 irq quiet after soft reset", {7'd0, irq}, 8'h00);

        finish_run();
    end

endmodule